// File: doc/BRIEF.md
# Single-Step Trap Controller

This block decides when a debug trap must be raised because of instruction stepping, inside a simple in-order retirement model. It holds the live processor flags word. Every retiring instruction presents the flags word it leaves behind. The block looks at the trap flag as it stood when that instruction began. If the flag was set, the instruction is allowed to complete, and one cycle later the block raises a one-cycle debug-exception request. On that trap it also sets a sticky single-step status bit, clears the live trap flag so that the handler runs unstepped, and keeps the flags image the instruction produced. The handler's return strobe loads that image back into the live flags, so stepping resumes.

A coarse mode is selected by one bit of a debug control word. In that mode a set trap flag fires only on control-transfer instructions: branches, calls, returns, interrupts and exceptions. While the handler-active input is high no new trap is raised, but the flags still follow the retiring instructions. The block also decides whether the trap condition holds, but fetch, decode, the flags arithmetic and vector dispatch belong to the surrounding core.

Top module: `sstep_trap_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the live flags (including the trap flag at bit 8), the saved image, the single-step status bit (bit 14 of the status word) and any pending request.
- R2: When a retiring instruction starts with flags bit 8 set, `trapReq` is high in the cycle after the retire strobe, for exactly one cycle.
- R3: An instruction that begins with bit 8 clear and writes it to 1 does not trap; the next retiring instruction does.
- R4: An instruction that begins with bit 8 set and writes it to 0 still traps; the instruction after it does not.
- R5: On a trap the live flags take the instruction's result with bit 8 forced to 0; without a trap they take the result unchanged.
- R6: On a trap `savedFlags` takes the instruction's full result, bit 8 included; a `handlerReturn` strobe loads `returnFlags` into the live flags, and a retire strobe in the same cycle is ignored.
- R7: A trap sets bit 14 of `dbgStatus`; all other status bits read 0.
- R8: Status bit 14 holds until a status write carries 0 in bit 14; a write with 1 there does not set it, and a trap in the same cycle as a clearing write leaves it set.
- R9: When bit 1 of `dbgCtl` is 1, a set trap flag traps only on instructions with `retireXfer` high; other instructions retire without a trap and keep their written flags.
- R10: While `handlerActive` is high no trap is raised and the status bit is unchanged, but the live flags still take each retiring result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retireValid | input | 1 | An instruction retires this cycle |
| retireXfer | input | 1 | The retiring instruction is a control transfer |
| retireFlags | input | 16 | Flags word the retiring instruction leaves |
| handlerReturn | input | 1 | Return from the debug handler this cycle |
| returnFlags | input | 16 | Flags image restored by the return |
| handlerActive | input | 1 | Debug handler is running |
| dbgCtl | input | 8 | Debug control word; bit 1 selects branch-only stepping |
| statWe | input | 1 | Software write to the status word |
| statWrData | input | 16 | Status write data; 0 in bit 14 clears it |
| trapReq | output | 1 | One-cycle debug-exception request |
| flagsOut | output | 16 | Live flags word |
| savedFlags | output | 16 | Flags image captured on the last trap |
| dbgStatus | output | 16 | Debug status word, bit 14 = single-step |

## Verification
The hardest case to reach is a trap whose retiring instruction simultaneously clears the trap flag and collides with a software status clear, since the trap flag must first be armed by an earlier instruction or by a handler return. The bench arms the flag through a return strobe, then retires the flag-clearing instruction in the same cycle as a clearing status write, and checks that the request, the saved image with bit 8 clear, and the status bit all come out as required, and that the next instruction retires untrapped.

// File: rtl/sstep_pkg.sv
package sstep_pkg;
  typedef struct packed {
    logic retire;   // apply retiring flags word
    logic restore;  // load handler return image
    logic trap;     // single-step trap taken on this retire
  } sstepStrobe_t;
endpackage

// File: rtl/sstep_ctrl.sv
module sstep_ctrl
  import sstep_pkg::*;
#(
  parameter int CTL_W   = 8,
  parameter int BTS_BIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retireValid,
  input  logic             retireXfer,
  input  logic             handlerReturn,
  input  logic             handlerActive,
  input  logic [CTL_W-1:0] dbgCtl,
  input  logic             tfAtStart,
  output sstepStrobe_t     strobe,
  output logic             trapReq
);
  logic branchOnly;
  logic stepHit;
  logic trapReqQ;

  assign branchOnly = dbgCtl[BTS_BIT];
  assign stepHit    = tfAtStart && (!branchOnly || retireXfer);

  always_comb begin
    strobe.restore = handlerReturn;
    strobe.retire  = retireValid && !handlerReturn;
    strobe.trap    = strobe.retire && stepHit && !handlerActive;
  end

  always_ff @(posedge clk) begin
    if (rst) trapReqQ <= 1'b0;
    else     trapReqQ <= strobe.trap;
  end

  assign trapReq = trapReqQ;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    trapReqQ |=> !trapReqQ); // R2

  AST_NO_TRAP_IN_HANDLER: assert property (@(posedge clk) disable iff (rst)
    handlerActive |=> !trapReqQ); // R10

  AST_BRANCH_ONLY: assert property (@(posedge clk) disable iff (rst)
    (retireValid && !retireXfer && dbgCtl[BTS_BIT]) |=> !trapReqQ); // R9
endmodule

// File: rtl/sstep_datapath.sv
module sstep_datapath
  import sstep_pkg::*;
#(
  parameter int FLAG_W = 16,
  parameter int TF_BIT = 8,
  parameter int STAT_W = 16,
  parameter int SS_BIT = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  sstepStrobe_t      strobe,
  input  logic [FLAG_W-1:0] retireFlags,
  input  logic [FLAG_W-1:0] returnFlags,
  input  logic              statWe,
  input  logic [STAT_W-1:0] statWrData,
  output logic              tfAtStart,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [FLAG_W-1:0] savedFlags,
  output logic [STAT_W-1:0] dbgStatus
);
  localparam logic [FLAG_W-1:0] TF_MASK = FLAG_W'(1) << TF_BIT;

  logic [FLAG_W-1:0] flagsQ;
  logic [FLAG_W-1:0] savedQ;
  logic              ssStatQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      flagsQ <= '0;
    end else if (strobe.restore) begin
      flagsQ <= returnFlags;
    end else if (strobe.retire) begin
      flagsQ <= strobe.trap ? (retireFlags & ~TF_MASK) : retireFlags;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              savedQ <= '0;
    else if (strobe.trap) savedQ <= retireFlags;
  end

  always_ff @(posedge clk) begin
    if (rst)                               ssStatQ <= 1'b0;
    else if (strobe.trap)                  ssStatQ <= 1'b1;
    else if (statWe && !statWrData[SS_BIT]) ssStatQ <= 1'b0;
  end

  assign tfAtStart  = flagsQ[TF_BIT];
  assign flagsOut   = flagsQ;
  assign savedFlags = savedQ;
  assign dbgStatus  = STAT_W'(ssStatQ) << SS_BIT;

  AST_TF_CLEAR_ON_TRAP: assert property (@(posedge clk) disable iff (rst)
    strobe.trap |=> !flagsQ[TF_BIT]); // R5

  AST_STATUS_ON_TRAP: assert property (@(posedge clk) disable iff (rst)
    strobe.trap |=> ssStatQ); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ssStatQ && !statWe) |=> ssStatQ); // R8

  AST_IMAGE_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst)
    strobe.trap |=> savedQ == $past(retireFlags)); // R6
endmodule

// File: rtl/sstep_trap_ctrl.sv
module sstep_trap_ctrl
  import sstep_pkg::*;
#(
  parameter int FLAG_W  = 16,
  parameter int TF_BIT  = 8,
  parameter int STAT_W  = 16,
  parameter int SS_BIT  = 14,
  parameter int CTL_W   = 8,
  parameter int BTS_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retireValid,
  input  logic              retireXfer,
  input  logic [FLAG_W-1:0] retireFlags,
  input  logic              handlerReturn,
  input  logic [FLAG_W-1:0] returnFlags,
  input  logic              handlerActive,
  input  logic [CTL_W-1:0]  dbgCtl,
  input  logic              statWe,
  input  logic [STAT_W-1:0] statWrData,
  output logic              trapReq,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [FLAG_W-1:0] savedFlags,
  output logic [STAT_W-1:0] dbgStatus
);
  sstepStrobe_t strobe;
  logic         tfAtStart;

  sstep_ctrl #(.CTL_W(CTL_W), .BTS_BIT(BTS_BIT)) uCtrl (
    .clk(clk), .rst(rst),
    .retireValid(retireValid), .retireXfer(retireXfer),
    .handlerReturn(handlerReturn), .handlerActive(handlerActive),
    .dbgCtl(dbgCtl), .tfAtStart(tfAtStart),
    .strobe(strobe), .trapReq(trapReq)
  );

  sstep_datapath #(.FLAG_W(FLAG_W), .TF_BIT(TF_BIT),
                   .STAT_W(STAT_W), .SS_BIT(SS_BIT)) uData (
    .clk(clk), .rst(rst), .strobe(strobe),
    .retireFlags(retireFlags), .returnFlags(returnFlags),
    .statWe(statWe), .statWrData(statWrData),
    .tfAtStart(tfAtStart), .flagsOut(flagsOut),
    .savedFlags(savedFlags), .dbgStatus(dbgStatus)
  );
endmodule

// File: tb/sstep_trap_ctrl_test.sv
module sstep_trap_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        retireValid, retireXfer, handlerReturn, handlerActive, statWe;
  logic [15:0] retireFlags, returnFlags, statWrData;
  logic [7:0]  dbgCtl;
  logic        trapReq;
  logic [15:0] flagsOut, savedFlags, dbgStatus;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  sstep_trap_ctrl uut (
    .clk(clk), .rst(rst), .retireValid(retireValid), .retireXfer(retireXfer),
    .retireFlags(retireFlags), .handlerReturn(handlerReturn),
    .returnFlags(returnFlags), .handlerActive(handlerActive), .dbgCtl(dbgCtl),
    .statWe(statWe), .statWrData(statWrData), .trapReq(trapReq),
    .flagsOut(flagsOut), .savedFlags(savedFlags), .dbgStatus(dbgStatus)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive one retiring instruction; returns after the edge that registers it
  task automatic retire(input logic xfer, input logic [15:0] res);
    @(negedge clk);
    retireValid = 1'b1; retireXfer = xfer; retireFlags = res;
    @(negedge clk);
    retireValid = 1'b0; retireXfer = 1'b0;
  endtask

  task automatic doReturn(input logic [15:0] img);
    @(negedge clk);
    handlerReturn = 1'b1; returnFlags = img;
    @(negedge clk);
    handlerReturn = 1'b0;
  endtask

  task automatic clrStatus();
    @(negedge clk);
    statWe = 1'b1; statWrData = 16'h0000;
    @(negedge clk);
    statWe = 1'b0;
  endtask

  task automatic testReset();
    doReturn(16'h0103);
    retire(1'b0, 16'h0105);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 flags", flagsOut, 16'h0000);
    chk("R1 saved", savedFlags, 16'h0000);
    chk("R1 status", dbgStatus, 16'h0000);
    chk("R1 req", {15'b0, trapReq}, 16'h0000);
  endtask

  task automatic testSetAndStep();
    retire(1'b0, 16'h0100);
    chk("R3 no trap on setter", {15'b0, trapReq}, 16'h0000);
    chk("R3 flag armed", flagsOut, 16'h0100);
    retire(1'b0, 16'h0182);
    chk("R2 trap req", {15'b0, trapReq}, 16'h0001);
    chk("R5 tf cleared", flagsOut, 16'h0082);
    chk("R6 image", savedFlags, 16'h0182);
    chk("R7 status", dbgStatus, 16'h4000);
    @(negedge clk);
    chk("R2 one cycle", {15'b0, trapReq}, 16'h0000);
    retire(1'b0, 16'h0002);
    chk("R5 handler not stepped", {15'b0, trapReq}, 16'h0000);
    chk("R5 plain write", flagsOut, 16'h0002);
  endtask

  task automatic testSticky();
    repeat (3) @(negedge clk);
    chk("R8 held", dbgStatus, 16'h4000);
    @(negedge clk); statWe = 1'b1; statWrData = 16'h4000;
    @(negedge clk); statWe = 1'b0;
    chk("R8 write 1 keeps", dbgStatus, 16'h4000);
    clrStatus();
    chk("R8 cleared", dbgStatus, 16'h0000);
    @(negedge clk); statWe = 1'b1; statWrData = 16'hFFFF;
    @(negedge clk); statWe = 1'b0;
    chk("R8 write 1 no set", dbgStatus, 16'h0000);
  endtask

  task automatic testReturnResumes();
    doReturn(16'h0182);
    chk("R6 restored", flagsOut, 16'h0182);
    retire(1'b0, 16'h0183);
    chk("R6 stepping resumes", {15'b0, trapReq}, 16'h0001);
    // retire ignored when return strobes in same cycle
    @(negedge clk);
    handlerReturn = 1'b1; returnFlags = 16'h0011;
    retireValid = 1'b1; retireFlags = 16'h0122;
    @(negedge clk);
    handlerReturn = 1'b0; retireValid = 1'b0;
    chk("R6 retire ignored", flagsOut, 16'h0011);
    chk("R6 no trap", {15'b0, trapReq}, 16'h0000);
    clrStatus();
  endtask

  task automatic testClearerCollide();
    doReturn(16'h0100);
    @(negedge clk);
    retireValid = 1'b1; retireFlags = 16'h0040;
    statWe = 1'b1; statWrData = 16'h0000;
    @(negedge clk);
    retireValid = 1'b0; statWe = 1'b0;
    chk("R4 last trap", {15'b0, trapReq}, 16'h0001);
    chk("R4 image tf clear", savedFlags, 16'h0040);
    chk("R8 set wins", dbgStatus, 16'h4000);
    doReturn(savedFlags);
    retire(1'b0, 16'h0040);
    chk("R4 no trap after", {15'b0, trapReq}, 16'h0000);
    clrStatus();
  endtask

  task automatic testBranchMode();
    dbgCtl = 8'h02;
    doReturn(16'h0100);
    retire(1'b0, 16'h0104);
    chk("R9 plain no trap", {15'b0, trapReq}, 16'h0000);
    chk("R9 flags kept", flagsOut, 16'h0104);
    chk("R9 status clear", dbgStatus, 16'h0000);
    retire(1'b1, 16'h0108);
    chk("R9 xfer traps", {15'b0, trapReq}, 16'h0001);
    chk("R9 tf cleared", flagsOut, 16'h0008);
    dbgCtl = 8'h00;
    clrStatus();
  endtask

  task automatic testHandlerActive();
    doReturn(16'h0100);
    handlerActive = 1'b1;
    retire(1'b1, 16'h0120);
    chk("R10 no trap", {15'b0, trapReq}, 16'h0000);
    chk("R10 flags follow", flagsOut, 16'h0120);
    chk("R10 status", dbgStatus, 16'h0000);
    handlerActive = 1'b0;
    retire(1'b0, 16'h0120);
    chk("R10 traps after", {15'b0, trapReq}, 16'h0001);
  endtask

  initial begin
    rst = 1'b1; retireValid = 0; retireXfer = 0; handlerReturn = 0;
    handlerActive = 0; statWe = 0; retireFlags = '0; returnFlags = '0;
    statWrData = '0; dbgCtl = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset flags", flagsOut, 16'h0000);
    chk("R1 reset status", dbgStatus, 16'h0000);
    testSetAndStep();
    testSticky();
    testReturnResumes();
    testClearerCollide();
    testBranchMode();
    testHandlerActive();
    testReset();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule